// File: doc/BRIEF.md
# Smart card activation sequencer

This block brings up a smart card's contacts in a fixed, timed order when a host asks for a session. It sits in a quiet shutdown state, with the oscillator at its slow rate and every contact control off, until the active-low session command falls. It then counts a fixed number of slow-oscillator ticks, switches the oscillator to its fast rate and enables the card supply at the same moment. From then on it counts fast-oscillator ticks in half-period steps: the data line is released high, a window opens in which the host may start the card clock, the window closes, and finally card reset is enabled and the session is reported active.

The fast-phase offsets are fractional multiples of a period T of 64 fast cycles (8.5 T for the data line, 11.5 T for reset), so the fast counter advances in half-T steps of 32 ticks and every offset lands on a step boundary. If the host releases the command at any point after the start, the block turns the outputs off in the reverse order, one fast tick apart, and returns to shutdown. The command input passes through a configurable synchronizer before the state machine sees it; the two tick inputs are one-cycle enables that come from the oscillator logic.

Top module: `scard_act_seq`

## Requirements
- R1: During reset and in shutdown, osc_fast, supply_en, io_drive, clk_window, card_rst_en and active are all 0 (0 on osc_fast selects the slow rate).
- R2: An activation starts only on a high-to-low transition of sess_req_n as seen after SYNC_STAGES register stages; a command held low from reset never starts one.
- R3: osc_fast and supply_en rise together on the clock edge that samples the 384th slow_tick after the start.
- R4: io_drive rises on the edge that samples the 544th fast_tick counted from the fast switch (17 half-steps of 32 ticks).
- R5: clk_window rises on the edge that samples the 545th fast_tick and falls on the edge that samples the 735th, so it lies strictly between the data release and reset.
- R6: card_rst_en and active rise together on the edge that samples the 736th fast_tick (23 half-steps) and then stay high while the command is low.
- R7: At all times io_drive implies supply_en, clk_window implies io_drive, and card_rst_en excludes clk_window.
- R8: If sess_req_n is seen high during the slow wait, the block returns to shutdown at the next edge with all outputs still 0.
- R9: If sess_req_n is seen high in the fast phase or while active, card_rst_en and active drop at the next edge; clk_window drops at the first following fast_tick, io_drive at the second, and supply_en with osc_fast at the third, after which the block is in shutdown.
- R10: When the command is seen high on the same edge as the 384th slow tick or the 736th fast tick, the abort wins: the fast switch or reset enable does not happen.
- R11: slow_tick is ignored outside the slow wait and fast_tick is ignored outside the fast phase and teardown; neither changes any output in shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sess_req_n | input | 1 | Active-low session command from the host |
| slow_tick | input | 1 | One-cycle enable per slow-oscillator cycle |
| fast_tick | input | 1 | One-cycle enable per fast-oscillator cycle |
| osc_fast | output | 1 | Oscillator rate select, 1 = fast |
| supply_en | output | 1 | Card supply enable |
| io_drive | output | 1 | Drive the card data line high |
| clk_window | output | 1 | Card clock may be applied while 1 |
| card_rst_en | output | 1 | Card reset enable |
| active | output | 1 | Activation complete |

## Verification
Two functions can fall on one edge: the host's release of the command and a tick that completes a phase, either the 384th slow tick or the 736th fast tick. The bench provokes both by lowering or raising sess_req_n exactly SYNC_STAGES cycles ahead of the tick it wants to hit, so the synchronized command and the completing tick reach the state machine on the same edge. It judges the outcome by requiring that osc_fast or card_rst_en never rises and that the shutdown or teardown sequence follows on the ticks its own model predicts.

// File: rtl/scard_act_pkg.sv
package scard_act_pkg;

   typedef enum logic [2:0] {
      SEQ_SHUT = 3'd0,
      SEQ_SLOW = 3'd1,
      SEQ_FAST = 3'd2,
      SEQ_ON   = 3'd3,
      SEQ_DOWN = 3'd4
   } seq_state_e;

   // teardown steps after the reset drop: window, data, supply
   localparam int unsigned DOWN_LAST = 2;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 1) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/scard_cmd_sync.sv
module scard_cmd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_direct
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] pipe;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[0] <= 1'b0;
            else        pipe[0] <= d_i;
         end

         for (genvar k = 1; k < STAGES; k++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[k] <= 1'b0;
               else        pipe[k] <= pipe[k-1];
            end
         end

         assign q_o = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/scard_wrap_counter.sv
module scard_wrap_counter #(
   parameter int unsigned MAX = 1,
   parameter int unsigned W   = scard_act_pkg::cnt_width(MAX)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);

   generate
      if (W < 32 && MAX >= (64'd1 << W)) begin : g_bad_width
         $error("scard_wrap_counter: W too small for MAX");
      end
   endgenerate

   assign wrap_o = inc_i && !clr_i && (cnt_o == W'(MAX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_o <= '0;
      else if (clr_i)  cnt_o <= '0;
      else if (wrap_o) cnt_o <= '0;
      else if (inc_i)  cnt_o <= cnt_o + W'(1);
   end

endmodule

// File: rtl/scard_act_seq.sv
module scard_act_seq
   import scard_act_pkg::*;
#(
   parameter int unsigned SLOW_CYC    = 384,
   parameter int unsigned HALF_T      = 32,
   parameter int unsigned DAT_HALVES  = 17,
   parameter int unsigned RST_HALVES  = 23,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sess_req_n,
   input  logic slow_tick,
   input  logic fast_tick,
   output logic osc_fast,
   output logic supply_en,
   output logic io_drive,
   output logic clk_window,
   output logic card_rst_en,
   output logic active
);

   localparam int unsigned SW = cnt_width(SLOW_CYC - 1);
   localparam int unsigned HW = cnt_width(HALF_T - 1);
   localparam int unsigned NW = cnt_width(RST_HALVES - 1);

   generate
      if (SLOW_CYC < 1) begin : g_bad_slow
         $error("scard_act_seq: SLOW_CYC must be at least 1");
      end
      if (HALF_T < 2) begin : g_bad_half
         $error("scard_act_seq: HALF_T must be at least 2");
      end
      if (DAT_HALVES < 1 || DAT_HALVES >= RST_HALVES) begin : g_bad_order
         $error("scard_act_seq: need 1 <= DAT_HALVES < RST_HALVES");
      end
      if ((RST_HALVES - DAT_HALVES) * HALF_T < 3) begin : g_bad_window
         $error("scard_act_seq: clock window would be empty");
      end
   endgenerate

   seq_state_e      state;
   logic            cmd_s;
   logic            cmd_q;
   logic [1:0]      down_step;

   logic [SW-1:0]   slow_cnt;
   logic            slow_done;
   logic [HW-1:0]   sub_cnt;
   logic            sub_wrap;
   logic [NW-1:0]   half_cnt;
   logic            half_done;

   logic            slow_inc;
   logic            fast_inc;
   logic            dat_ev;
   logic            open_ev;
   logic            close_ev;

   scard_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sess_req_n),
      .q_o   (cmd_s)
   );

   assign slow_inc = slow_tick && (state == SEQ_SLOW) && !cmd_s;
   assign fast_inc = fast_tick && (state == SEQ_FAST) && !cmd_s;

   scard_wrap_counter #(.MAX(SLOW_CYC - 1), .W(SW)) u_slow_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (state != SEQ_SLOW),
      .inc_i  (slow_inc),
      .cnt_o  (slow_cnt),
      .wrap_o (slow_done)
   );

   scard_wrap_counter #(.MAX(HALF_T - 1), .W(HW)) u_sub_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (state != SEQ_FAST),
      .inc_i  (fast_inc),
      .cnt_o  (sub_cnt),
      .wrap_o (sub_wrap)
   );

   scard_wrap_counter #(.MAX(RST_HALVES - 1), .W(NW)) u_half_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (state != SEQ_FAST),
      .inc_i  (sub_wrap),
      .cnt_o  (half_cnt),
      .wrap_o (half_done)
   );

   // fast-phase events, all in half-T step coordinates
   assign dat_ev   = sub_wrap && (half_cnt == NW'(DAT_HALVES - 1));
   assign open_ev  = fast_inc && (sub_cnt == '0) && (half_cnt == NW'(DAT_HALVES));
   assign close_ev = fast_inc && (sub_cnt == HW'(HALF_T - 2))
                     && (half_cnt == NW'(RST_HALVES - 1));

   assign active = (state == SEQ_ON);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= SEQ_SHUT;
         cmd_q       <= 1'b0;
         down_step   <= '0;
         osc_fast    <= 1'b0;
         supply_en   <= 1'b0;
         io_drive    <= 1'b0;
         clk_window  <= 1'b0;
         card_rst_en <= 1'b0;
      end else begin
         cmd_q <= cmd_s;
         unique case (state)
            SEQ_SHUT: begin
               if (!cmd_s && cmd_q) state <= SEQ_SLOW;
            end
            SEQ_SLOW: begin
               if (cmd_s) begin
                  state <= SEQ_SHUT;
               end else if (slow_done) begin
                  state     <= SEQ_FAST;
                  osc_fast  <= 1'b1;
                  supply_en <= 1'b1;
               end
            end
            SEQ_FAST: begin
               if (cmd_s) begin
                  state       <= SEQ_DOWN;
                  down_step   <= '0;
                  card_rst_en <= 1'b0;
               end else begin
                  if (dat_ev)   io_drive   <= 1'b1;
                  if (open_ev)  clk_window <= 1'b1;
                  if (close_ev) clk_window <= 1'b0;
                  if (half_done) begin
                     card_rst_en <= 1'b1;
                     state       <= SEQ_ON;
                  end
               end
            end
            SEQ_ON: begin
               if (cmd_s) begin
                  state       <= SEQ_DOWN;
                  down_step   <= '0;
                  card_rst_en <= 1'b0;
               end
            end
            SEQ_DOWN: begin
               if (fast_tick) begin
                  if (down_step == 2'd0) begin
                     clk_window <= 1'b0;
                     down_step  <= 2'd1;
                  end else if (down_step == 2'd1) begin
                     io_drive  <= 1'b0;
                     down_step <= 2'(DOWN_LAST);
                  end else begin
                     supply_en <= 1'b0;
                     osc_fast  <= 1'b0;
                     down_step <= '0;
                     state     <= SEQ_SHUT;
                  end
               end
            end
            default: state <= SEQ_SHUT;
         endcase
      end
   end

endmodule

// File: rtl/scard_act_seq_chk.sv
module scard_act_seq_chk
   import scard_act_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_s,
   input logic       slow_tick,
   input logic       fast_tick,
   input logic [2:0] state,
   input logic       osc_fast,
   input logic       supply_en,
   input logic       io_drive,
   input logic       clk_window,
   input logic       card_rst_en,
   input logic       active
);

   a_r1_shutdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_SHUT) |-> !(osc_fast || supply_en || io_drive || clk_window
                               || card_rst_en || active));

   a_r3_fast_with_supply: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_fast) |-> ($rose(supply_en) && $past(slow_tick)));

   a_r4_data_on_fast_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(io_drive) |-> ($past(fast_tick) && ($past(state) == SEQ_FAST)));

   a_r5_window_after_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_window) |-> ($past(fast_tick) && $past(io_drive)));

   a_r6_reset_with_active: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_rst_en) |-> ($past(fast_tick) && $rose(active)));

   a_r6_active_needs_reset: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> card_rst_en);

   a_r7_order: assert property (@(posedge clk) disable iff (!rst_n)
      (io_drive |-> supply_en) and (clk_window |-> io_drive)
      and (card_rst_en |-> !clk_window));

   a_r8_slow_abort: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == SEQ_SLOW) && cmd_s) |=> ((state == SEQ_SHUT) && !osc_fast));

   a_r9_reset_drops_first: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_s && card_rst_en) |=> !card_rst_en);

   a_r9_supply_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(supply_en) |-> (!io_drive && !clk_window && !osc_fast && $past(fast_tick)));

   a_r10_abort_beats_reset: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == SEQ_FAST) && cmd_s) |=> (!card_rst_en && !active));

endmodule

bind scard_act_seq scard_act_seq_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_s       (cmd_s),
   .slow_tick   (slow_tick),
   .fast_tick   (fast_tick),
   .state       (state),
   .osc_fast    (osc_fast),
   .supply_en   (supply_en),
   .io_drive    (io_drive),
   .clk_window  (clk_window),
   .card_rst_en (card_rst_en),
   .active      (active)
);

// File: tb/tb_scard_act_seq.sv
module tb_scard_act_seq;

   localparam int SYNC   = 2;
   localparam int N_SLOW = 384;
   localparam int HALF   = 32;
   localparam int N_DAT  = 17 * HALF;   // 544
   localparam int N_RST  = 23 * HALF;   // 736

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sess_req_n = 1'b0;
   logic slow_tick = 1'b0;
   logic fast_tick = 1'b0;
   logic osc_fast, supply_en, io_drive, clk_window, card_rst_en, active;

   always #5 clk = ~clk;

   scard_act_seq #(.SYNC_STAGES(SYNC)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .sess_req_n  (sess_req_n),
      .slow_tick   (slow_tick),
      .fast_tick   (fast_tick),
      .osc_fast    (osc_fast),
      .supply_en   (supply_en),
      .io_drive    (io_drive),
      .clk_window  (clk_window),
      .card_rst_en (card_rst_en),
      .active      (active)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit cmd_lvl = 1'b0;

   // reference model: 0 shutdown, 1 slow wait, 2 fast/active, 3 teardown
   int ph = 0;
   int ns = 0;
   int nf = 0;
   int nd = 0;
   bit w0 = 0;
   bit d0 = 0;

   function automatic bit e_fast();
      return (ph == 2) || (ph == 3 && nd < 3);
   endfunction
   function automatic bit e_io();
      return (ph == 2 && nf >= N_DAT) || (ph == 3 && d0 && nd < 2);
   endfunction
   function automatic bit e_win();
      return (ph == 2 && nf >= N_DAT + 1 && nf < N_RST - 1) || (ph == 3 && w0 && nd < 1);
   endfunction
   function automatic bit e_rst();
      return (ph == 2 && nf >= N_RST);
   endfunction

   task automatic chk(input bit got, input bit exp, input string req,
                      input string name, input string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s (%s) %s: got %0b expected %0b", req, tag, name, got, exp);
      end
   endtask

   task automatic model(input bit s, input bit f, input int ev);
      if (ev == 2) begin
         if (ph == 1) ph = 0;
         else if (ph == 2) begin
            w0 = e_win();
            d0 = e_io();
            nd = 0;
            ph = 3;
         end
      end else if (ev == 1) begin
         ph = 1;
         ns = 0;
      end else begin
         case (ph)
            1: if (s) begin
                  ns++;
                  if (ns == N_SLOW) begin ph = 2; nf = 0; end
               end
            2: if (f && nf < N_RST) nf++;
            3: if (f) begin
                  nd++;
                  if (nd == 3) ph = 0;
               end
            default: ;
         endcase
      end
   endtask

   task automatic compare(input string tag);
      bit order_ok;
      chk(osc_fast,    e_fast(), "R3", "osc_fast",    tag);
      chk(supply_en,   e_fast(), "R3", "supply_en",   tag);
      chk(io_drive,    e_io(),   "R4", "io_drive",    tag);
      chk(clk_window,  e_win(),  "R5", "clk_window",  tag);
      chk(card_rst_en, e_rst(),  "R6", "card_rst_en", tag);
      chk(active,      e_rst(),  "R6", "active",      tag);
      order_ok = (!io_drive || supply_en) && (!clk_window || io_drive)
                 && !(card_rst_en && clk_window);
      chk(order_ok, 1'b1, "R7", "ordering", tag);
   endtask

   // one clock: drive at the falling edge, update model at the rising edge,
   // compare shortly after
   task automatic cyc(input bit s, input bit f, input int ev, input string tag);
      @(negedge clk);
      slow_tick  = s;
      fast_tick  = f;
      sess_req_n = cmd_lvl;
      @(posedge clk);
      if (rst_n) model(s, f, ev);
      #2;
      compare(tag);
   endtask

   // change the command so the synchronized value reaches the FSM on the
   // last of SYNC+1 cycles, which carries the given ticks
   task automatic sync_cmd(input bit lvl, input bit s, input bit f, input string tag);
      cmd_lvl = lvl;
      for (int k = 0; k <= SYNC; k++) begin
         if (k == SYNC) cyc(s, f, lvl ? 2 : 1, tag);
         else           cyc(1'b0, 1'b0, 0, tag);
      end
   endtask

   task automatic advance(input int want_ph, input int cnt, input bit rnd, input string tag);
      while (!(ph == want_ph && ((want_ph == 1) ? ns : nf) == cnt)) begin
         bit s, f;
         if (rnd) begin
            s = 1'($urandom % 2);
            f = 1'($urandom % 2);
         end else begin
            s = (ph == 1);
            f = (ph == 2);
         end
         cyc(s, f, 0, tag);
      end
   endtask

   task automatic drain(input string tag);
      while (ph != 0) cyc(1'($urandom % 2), 1'($urandom % 2), 0, tag);
      repeat (5) cyc(1'($urandom % 2), 1'($urandom % 2), 0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: got still running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5171));
      // R1: outputs quiet while in reset
      repeat (4) cyc(1'b0, 1'b0, 0, "R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      // R2: command low from reset must not start; R11 ticks do nothing
      repeat (40) cyc(1'($urandom % 2), 1'($urandom % 2), 0, "R2 low held from reset");
      sync_cmd(1'b1, 1'b0, 1'b0, "R1 command released");
      repeat (20) cyc(1'($urandom % 2), 1'($urandom % 2), 0, "R11 ticks in shutdown");

      // full activation with mixed random ticks, abort while active
      sync_cmd(1'b0, 1'b0, 1'b0, "R2 start");
      advance(2, N_RST, 1'b1, "R11 mixed ticks to active");
      repeat (30) cyc(1'($urandom % 2), 1'($urandom % 2), 0, "R6 hold active");
      sync_cmd(1'b1, 1'b0, 1'b0, "R9 abort while active");
      drain("R9 teardown from active");

      // abort in the middle of the slow wait
      sync_cmd(1'b0, 1'b0, 1'b0, "R2 restart");
      advance(1, 200, 1'b1, "R8 slow wait");
      sync_cmd(1'b1, 1'b0, 1'b0, "R8 abort in slow wait");
      repeat (20) cyc(1'($urandom % 2), 1'($urandom % 2), 0, "R8 after slow abort");

      // abort on the same edge as the last slow tick
      sync_cmd(1'b0, 1'b0, 1'b0, "R2 restart");
      advance(1, N_SLOW - 1, 1'b0, "R3 slow count");
      sync_cmd(1'b1, 1'b1, 1'b1, "R10 abort on last slow tick");
      repeat (20) cyc(1'($urandom % 2), 1'($urandom % 2), 0, "R10 after slow collision");

      // abort on the same edge as the reset-enable tick
      sync_cmd(1'b0, 1'b0, 1'b0, "R2 restart");
      advance(2, N_RST - 1, 1'b1, "R5 window closes");
      sync_cmd(1'b1, 1'b0, 1'b1, "R10 abort on reset tick");
      drain("R10 teardown after collision");

      // abort with the clock window open
      sync_cmd(1'b0, 1'b0, 1'b0, "R2 restart");
      advance(2, 600, 1'b1, "R5 window open");
      sync_cmd(1'b1, 1'b0, 1'b0, "R9 abort inside window");
      drain("R9 teardown from window");

      // abort early in the fast phase, before data release
      sync_cmd(1'b0, 1'b0, 1'b0, "R2 restart");
      advance(2, 100, 1'b1, "R4 before data");
      sync_cmd(1'b1, 1'b0, 1'b0, "R9 abort before data");
      drain("R9 teardown before data");

      // abort exactly at the data-release tick boundary
      sync_cmd(1'b0, 1'b0, 1'b0, "R2 restart");
      advance(2, N_DAT, 1'b0, "R4 data release");
      sync_cmd(1'b1, 1'b0, 1'b0, "R9 abort at data release");
      drain("R9 teardown at data release");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule